// File: doc/BRIEF.md
# Framed Serial Word Deserializer with Embedded-Edge Lock

This block turns a stream of already-sampled serial bits into 10-bit words. One bit arrives on each cycle in which the bit enable is high. Every word travels in a 12-slot frame. The frame opens with a start slot that is always 1, carries the payload least significant bit first, and closes with a stop slot that is always 0. The 0-to-1 step from one frame's stop slot into the next frame's start slot is the only timing reference in the stream. The block uses that edge to find where frames begin.

After reset or powerdown the block hunts for that edge and aligns its slot counter to it. It then trains on the edge for 80 consecutive frame periods before it reports lock. Lock is reported on an active-low flag. Payload words, each with a one-cycle strobe, appear only while locked. If the edge is missing at two frame boundaries in a row, the block drops lock and starts hunting again without outside help. An output-enable input hides the word, strobe and lock outputs without disturbing the internal state. A separate active-high flag shows whether the outputs are currently driven.

Top module: `fr_deser`

## Requirements
- R1: The payload bits follow the start slot, lowest bit first. While locked, the 10-bit word captured when a frame's stop slot arrives equals that frame's payload.
- R2: The word strobe is high for exactly one cycle per locked frame, starting the cycle after the stop slot is accepted. It never pulses while the lock flag is high.
- R3: The lock flag goes low on the cycle after the start slot of the 80th consecutive correctly framed frame is accepted. After 79 such frames it is still high.
- R4: During training, a frame boundary without a 0-to-1 edge throws away the frame count. Lock then needs a fresh run of 80 good frames.
- R5: While locked, a single missing edge keeps lock. A correct edge clears the miss count, so isolated misses never add up.
- R6: While locked, two missing edges at consecutive frame boundaries raise the lock flag on the cycle after the second miss. The strobe then stays low and the block hunts again, so it can regain lock later.
- R7: While powerdown is low, the lock flag is high and the output-enable flag is low. All internal state is cleared, so after release the block needs a full 80-frame run to lock.
- R8: While output enable is low, the output-enable flag is low, the lock flag is high, the word is all zeros and the strobe is low. When output enable returns high, the earlier lock state shows again without any new training.
- R9: The synchronous active-low reset has the same effect as powerdown. While it is low, the lock flag is high, the strobe is low and the output-enable flag is low.
- R10: Cycles with the bit enable low do not advance the slot position or the bit history, whatever the serial input does on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwrdn_n | input | 1 | Powerdown, active low; clears the block |
| oe | input | 1 | Output enable, active high |
| bit_en | input | 1 | Marks a cycle that carries a serial bit |
| bit_in | input | 1 | Serial bit |
| word_out | output | 10 | Recovered payload word |
| word_stb | output | 1 | One-cycle strobe for a new word |
| lock_n | output | 1 | Lock flag, low when locked |
| out_en | output | 1 | High while the outputs are driven |

## Verification
The hardest state to reach from the ports is a locked block with exactly one outstanding miss. The single-miss case must be told apart from the two-miss case. The stimulus reaches both by sending a frame whose stop slot is 1, which removes the edge at the next boundary. It does this once, and then twice back to back, with good frames in between to clear the count. The exact lock threshold is checked by sampling the lock flag after frame 79 and again right after the start slot of frame 80. Training restart is shown by breaking a run at frame 50 and confirming that 79 further good frames do not lock.

// File: rtl/fr_deser_pkg.sv
// Package: frame geometry defaults and the lock-state encoding shared by
// the deserializer sub-blocks.
package fr_deser_pkg;
    localparam int DEF_DATA_W      = 10;
    localparam int DEF_LOCK_FRAMES = 80;
    localparam int DEF_MISS_LIMIT  = 2;

    typedef enum logic [1:0] {
        LK_HUNT  = 2'd0,
        LK_TRAIN = 2'd1,
        LK_HOLD  = 2'd2
    } lk_state_e;
endpackage

// File: rtl/fr_deser_align.sv
// Slot tracker: keeps the previous serial bit, a shift register of the most
// recent DATA_W bits (first-received bit ends at index 0) and the slot number
// expected for the next accepted bit. Assumes bits are qualified by bit_en;
// realign marks the current bit as slot 0 (a start slot).
module fr_deser_align #(
    parameter int DATA_W  = 10,
    parameter int FRAME_W = DATA_W + 2,
    parameter int SLOT_W  = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              realign,
    output logic [SLOT_W-1:0] slot,
    output logic              edge_seen,
    output logic [DATA_W-1:0] data_sr
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_W - 1);

    logic [SLOT_W-1:0] slot_q;
    logic              prev_q;
    logic [DATA_W-1:0] sr_q;

    // Advance the slot counter, history bit and payload shifter on each accepted bit.
    always_ff @(posedge clk) begin
        if (clr) begin
            slot_q <= '0;
            prev_q <= 1'b0;
            sr_q   <= '0;
        end else if (bit_en) begin
            prev_q <= bit_in;
            sr_q   <= {bit_in, sr_q[DATA_W-1:1]};
            if (realign)
                slot_q <= SLOT_W'(1);
            else if (slot_q == LAST_SLOT)
                slot_q <= '0;
            else
                slot_q <= slot_q + SLOT_W'(1);
        end
    end

    // Expose the slot of the arriving bit and the stop-to-start edge test.
    always_comb begin
        slot      = slot_q;
        edge_seen = !prev_q && bit_in;
        data_sr   = sr_q;
    end
endmodule

// File: rtl/fr_deser_lockfsm.sv
// Lock controller: hunts for a 0-to-1 edge, trains on it for LOCK_FRAMES
// frame boundaries, then holds lock until MISS_LIMIT boundaries in a row lack
// the edge. Assumes slot 0 marks the bit expected to be a start slot.
module fr_deser_lockfsm
    import fr_deser_pkg::*;
#(
    parameter int LOCK_FRAMES = 80,
    parameter int MISS_LIMIT  = 2,
    parameter int SLOT_W      = 4
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              bit_en,
    input  logic              edge_seen,
    input  logic [SLOT_W-1:0] slot,
    output logic              realign,
    output logic              locked
);
    localparam int CNT_W  = $clog2(LOCK_FRAMES + 1);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);

    lk_state_e         st_q;
    logic [CNT_W-1:0]  good_q;
    logic [MISS_W-1:0] miss_q;
    logic              at_start;

    // Decode the boundary slot and the realign request during hunting.
    always_comb begin
        at_start = (slot == '0);
        realign  = (st_q == LK_HUNT) && bit_en && edge_seen;
        locked   = (st_q == LK_HOLD);
    end

    // Step the hunt/train/hold sequence on each accepted bit.
    always_ff @(posedge clk) begin
        if (clr) begin
            st_q   <= LK_HUNT;
            good_q <= '0;
            miss_q <= '0;
        end else if (bit_en) begin
            unique case (st_q)
                LK_HUNT: begin
                    if (edge_seen) begin
                        st_q   <= LK_TRAIN;
                        good_q <= CNT_W'(1);
                    end
                end
                LK_TRAIN: begin
                    if (at_start) begin
                        if (!edge_seen) begin
                            st_q   <= LK_HUNT;
                            good_q <= '0;
                        end else if (good_q == CNT_W'(LOCK_FRAMES - 1)) begin
                            st_q   <= LK_HOLD;
                            good_q <= '0;
                            miss_q <= '0;
                        end else begin
                            good_q <= good_q + CNT_W'(1);
                        end
                    end
                end
                LK_HOLD: begin
                    if (at_start) begin
                        if (edge_seen) begin
                            miss_q <= '0;
                        end else if (miss_q == MISS_W'(MISS_LIMIT - 1)) begin
                            st_q   <= LK_HUNT;
                            miss_q <= '0;
                        end else begin
                            miss_q <= miss_q + MISS_W'(1);
                        end
                    end
                end
                default: st_q <= LK_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/fr_deser_outstage.sv
// Output stage: captures the payload when a locked frame's stop slot arrives,
// pulses the strobe for one cycle, and masks word, strobe and lock while the
// outputs are not driven. Assumes data_sr already holds the ten payload bits
// when the stop slot is presented.
module fr_deser_outstage #(
    parameter int DATA_W  = 10,
    parameter int FRAME_W = DATA_W + 2,
    parameter int SLOT_W  = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              locked,
    input  logic              bit_en,
    input  logic [SLOT_W-1:0] slot,
    input  logic [DATA_W-1:0] data_sr,
    input  logic              drive_en,
    output logic [DATA_W-1:0] word_out,
    output logic              word_stb,
    output logic              lock_n
);
    localparam logic [SLOT_W-1:0] STOP_SLOT = SLOT_W'(FRAME_W - 1);

    logic              take;
    logic              stb_q;
    logic [DATA_W-1:0] word_q;

    // Qualify a capture: locked, bit accepted, and it is the stop slot.
    always_comb take = locked && bit_en && (slot == STOP_SLOT);

    // Register the word and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (clr) begin
            stb_q  <= 1'b0;
            word_q <= '0;
        end else begin
            stb_q <= take;
            if (take)
                word_q <= data_sr;
        end
    end

    // Mask the visible outputs while they are not driven.
    always_comb begin
        word_out = drive_en ? word_q : '0;
        word_stb = drive_en && stb_q;
        lock_n   = drive_en ? !locked : 1'b1;
    end
endmodule

// File: rtl/fr_deser.sv
// Top: framed serial deserializer with embedded-edge lock. Reset and
// powerdown both clear every sub-block synchronously; output enable only
// masks what leaves the block.
module fr_deser
    import fr_deser_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int LOCK_FRAMES = DEF_LOCK_FRAMES,
    parameter int MISS_LIMIT  = DEF_MISS_LIMIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrdn_n,
    input  logic              oe,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic [DATA_W-1:0] word_out,
    output logic              word_stb,
    output logic              lock_n,
    output logic              out_en
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int SLOT_W  = $clog2(FRAME_W);

    logic              clr;
    logic [SLOT_W-1:0] slot;
    logic              edge_seen;
    logic [DATA_W-1:0] data_sr;
    logic              realign;
    logic              locked;

    // Combine reset and powerdown into one clear; drive only when enabled and awake.
    always_comb begin
        clr    = !rst_n || !pwrdn_n;
        out_en = oe && pwrdn_n && rst_n;
    end

    fr_deser_align #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .SLOT_W(SLOT_W)) u_align (
        .clk(clk), .clr(clr), .bit_en(bit_en), .bit_in(bit_in), .realign(realign),
        .slot(slot), .edge_seen(edge_seen), .data_sr(data_sr)
    );

    fr_deser_lockfsm #(.LOCK_FRAMES(LOCK_FRAMES), .MISS_LIMIT(MISS_LIMIT), .SLOT_W(SLOT_W)) u_fsm (
        .clk(clk), .clr(clr), .bit_en(bit_en), .edge_seen(edge_seen), .slot(slot),
        .realign(realign), .locked(locked)
    );

    fr_deser_outstage #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .SLOT_W(SLOT_W)) u_out (
        .clk(clk), .clr(clr), .locked(locked), .bit_en(bit_en), .slot(slot),
        .data_sr(data_sr), .drive_en(out_en),
        .word_out(word_out), .word_stb(word_stb), .lock_n(lock_n)
    );
endmodule

// File: rtl/fr_deser_chk.sv
// Checker: temporal properties on the deserializer ports, bound to the top.
module fr_deser_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwrdn_n,
    input logic              oe,
    input logic              bit_en,
    input logic [DATA_W-1:0] word_out,
    input logic              word_stb,
    input logic              lock_n
);
    // R2
    stb_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> !lock_n);

    // R2
    stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> !word_stb);

    // R8
    oe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (lock_n && !word_stb && word_out == '0));

    // R7
    pwrdn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwrdn_n) |-> lock_n);

    // R3
    lock_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lock_n) && oe && $past(oe)) |-> $past(bit_en));

    // R6
    unlock_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lock_n) && oe && $past(oe) && pwrdn_n && $past(pwrdn_n)) |-> $past(bit_en));
endmodule

bind fr_deser fr_deser_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .oe(oe), .bit_en(bit_en),
    .word_out(word_out), .word_stb(word_stb), .lock_n(lock_n)
);

// File: tb/fr_deser_tb.sv
module fr_deser_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam logic [9:0] VEC_STIM [NVEC] = '{10'h000, 10'h3FF, 10'h155, 10'h2AA,
                                               10'h001, 10'h200, 10'h0F0, 10'h30F};
    localparam logic [9:0] VEC_EXP  [NVEC] = '{10'h000, 10'h3FF, 10'h155, 10'h2AA,
                                               10'h001, 10'h200, 10'h0F0, 10'h30F};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwrdn_n = 1'b1;
    logic oe = 1'b1;
    logic bit_en = 1'b0;
    logic bit_in = 1'b0;
    logic [9:0] word_out;
    logic word_stb, lock_n, out_en;

    int n_chk = 0;
    int n_bad = 0;
    int stb_cnt = 0;
    logic [9:0] last_word = '0;

    fr_deser u_dut (
        .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .oe(oe), .bit_en(bit_en),
        .bit_in(bit_in), .word_out(word_out), .word_stb(word_stb),
        .lock_n(lock_n), .out_en(out_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Strobe monitor, sampled a quarter period after the rising edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (word_stb) begin
            stb_cnt++;
            last_word = word_out;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        @(negedge clk);
        bit_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_tail(input logic [9:0] w, input bit bad_stop);
        for (int i = 0; i < 10; i++) send_bit(w[i]);
        send_bit(bad_stop ? 1'b1 : 1'b0);
    endtask

    task automatic send_frame(input logic [9:0] w, input bit bad_stop);
        send_bit(1'b1);
        send_tail(w, bad_stop);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    task automatic good_run(input int n);
        for (int i = 0; i < n; i++) send_frame(10'((i * 37 + 5) & 10'h3FF), 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int s0;
        // R9: reset state
        repeat (3) @(negedge clk);
        check(lock_n == 1'b1, "R9 lock_n in reset", lock_n, 1);
        check(word_stb == 1'b0, "R9 strobe in reset", word_stb, 0);
        check(out_en == 1'b0, "R9 out_en in reset", out_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_en == 1'b1, "R8 out_en after reset", out_en, 1);

        // R3: exact lock threshold
        idle(4);
        good_run(79);
        check(lock_n == 1'b1, "R3 unlocked after 79 frames", lock_n, 1);
        check(stb_cnt == 0, "R2 no strobe before lock", stb_cnt, 0);
        send_bit(1'b1);
        check(lock_n == 1'b0, "R3 locked on frame 80 start", lock_n, 0);
        send_tail(10'h2A5, 1'b0);
        check(stb_cnt == 1, "R2 first strobe", stb_cnt, 1);
        check(last_word == 10'h2A5, "R1 first word", last_word, 10'h2A5);

        // R1: table of payloads
        for (int v = 0; v < NVEC; v++) begin
            s0 = stb_cnt;
            send_frame(VEC_STIM[v], 1'b0);
            check(stb_cnt == s0 + 1, "R2 one strobe per frame", stb_cnt, s0 + 1);
            check(last_word == VEC_EXP[v], "R1 payload LSB first", last_word, VEC_EXP[v]);
        end

        // R5: isolated misses do not accumulate
        send_frame(10'h011, 1'b1);
        send_bit(1'b1);
        check(lock_n == 1'b0, "R5 lock kept after one miss", lock_n, 0);
        send_tail(10'h022, 1'b0);
        send_frame(10'h033, 1'b0);
        send_frame(10'h044, 1'b1);
        send_frame(10'h055, 1'b0);
        check(lock_n == 1'b0, "R5 lock kept after second isolated miss", lock_n, 0);
        check(last_word == 10'h055, "R1 word after isolated miss", last_word, 10'h055);

        // R10: bit_en low ignores the serial input
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            bit_in = i[0];
        end
        s0 = stb_cnt;
        send_frame(10'h1C3, 1'b0);
        check(lock_n == 1'b0 && stb_cnt == s0 + 1, "R10 idle cycles ignored", lock_n, 0);
        check(last_word == 10'h1C3, "R10 alignment kept", last_word, 10'h1C3);

        // R6: two back-to-back misses drop lock
        send_frame(10'h066, 1'b1);
        send_frame(10'h077, 1'b1);
        send_bit(1'b1);
        check(lock_n == 1'b1, "R6 lock lost after two misses", lock_n, 1);
        s0 = stb_cnt;
        send_tail(10'h088, 1'b0);
        send_frame(10'h099, 1'b0);
        check(stb_cnt == s0, "R6 no strobe after unlock", stb_cnt, s0);

        // R6: reacquire after loss
        idle(24);
        good_run(80);
        check(lock_n == 1'b0, "R6 relock after 80 frames", lock_n, 0);

        // R8: output enable masking and restore
        @(negedge clk);
        oe = 1'b0;
        @(negedge clk);
        check(out_en == 1'b0, "R8 out_en low", out_en, 0);
        check(lock_n == 1'b1, "R8 lock masked", lock_n, 1);
        check(word_out == 10'h0, "R8 word masked", word_out, 0);
        s0 = stb_cnt;
        send_frame(10'h3C3, 1'b0);
        check(stb_cnt == s0, "R8 no strobe while disabled", stb_cnt, s0);
        @(negedge clk);
        oe = 1'b1;
        @(negedge clk);
        check(lock_n == 1'b0, "R8 lock restored", lock_n, 0);
        send_frame(10'h12D, 1'b0);
        check(stb_cnt == s0 + 1 && last_word == 10'h12D, "R8 words resume", last_word, 10'h12D);

        // R7: powerdown clears and forces full reacquisition
        @(negedge clk);
        pwrdn_n = 1'b0;
        @(negedge clk);
        check(lock_n == 1'b1, "R7 lock high in powerdown", lock_n, 1);
        check(out_en == 1'b0, "R7 out_en low in powerdown", out_en, 0);
        @(negedge clk);
        pwrdn_n = 1'b1;
        @(negedge clk);
        check(lock_n == 1'b1, "R7 unlocked after release", lock_n, 1);
        idle(4);
        good_run(79);
        check(lock_n == 1'b1, "R7 still unlocked after 79 frames", lock_n, 1);
        send_frame(10'h0AA, 1'b0);
        check(lock_n == 1'b0, "R7 locked after 80 frames", lock_n, 0);

        // R4: a miss during training restarts the count
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle(4);
        good_run(50);
        send_frame(10'h155, 1'b1);
        idle(24);
        good_run(79);
        check(lock_n == 1'b1, "R4 count restarted", lock_n, 1);
        send_frame(10'h0F0, 1'b0);
        check(lock_n == 1'b0, "R4 locks after fresh 80", lock_n, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule